// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the order in which column addresses are visited during one burst of a double-data-rate memory access. A small mode register holds a burst length code and a wrap-order bit. A start pulse captures a starting column address together with the current mode. From the next cycle on, the block presents one column address per enabled clock. It flags the final beat, then returns to idle.

Two wrap orders are supported. Sequential order counts upward from the start offset and wraps inside the aligned block of burst length. Interleaved order is the start offset XOR the beat index. In both orders only the offset bits inside the burst are permuted, and the column bits above them stay at the value captured at start. A start pulse during a running burst cuts it short and begins a new one. A start pulse while the length code is reserved is dropped.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `beatValid` and `beatLast` are 0 and the mode register holds length code 000. A start pulse before any mode write therefore produces no beats.
- R2: The mode register loads `modeBits` on any clock edge where `modeWrEn` is 1. Bits [2:0] select the length: 001 gives 2 beats, 010 gives 4 and 011 gives 8. Bit 3 selects the order: 0 is sequential, 1 is interleaved. A start sampled on the same edge as a mode write uses the value held before that edge.
- R3: Length codes 000, 100, 101, 110 and 111 are reserved. A start sampled while one of them is held is ignored, and `beatValid` stays 0.
- R4: When a start is accepted on an edge, `beatValid` is 1 from the following cycle, and the first `beatCol` equals `startCol`.
- R5: In sequential order, beat i carries offset (s + i) mod L, where s is the start offset inside the burst and L is the length. Example: L=4, s=2 gives 2,3,0,1.
- R6: In interleaved order, beat i carries offset s XOR i. Example: L=8, s=5 gives 5,4,7,6,1,0,3,2.
- R7: Only `beatCol` bit 0 (L=2), bits [1:0] (L=4) or bits [2:0] (L=8) change within a burst. All higher bits keep the captured start value.
- R8: `beatLast` is 1 exactly on beat L-1 of a burst. After that beat is consumed with `beatEn` high, `beatValid` falls to 0.
- R9: While `beatEn` is 0, a valid beat holds: `beatCol`, `beatValid` and `beatLast` do not change.
- R10: An accepted start during a running burst abandons it. The next cycle shows the new burst's first beat.
- R11: Mode writes during a burst do not change its length or order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Load `modeBits` into the mode register |
| modeBits | input | 4 | [2:0] length code, [3] interleave select |
| start | input | 1 | Begin a burst at `startCol` |
| startCol | input | COL_W (11) | Starting column address |
| beatEn | input | 1 | Advance to the next beat |
| beatCol | output | COL_W (11) | Column address of the current beat |
| beatValid | output | 1 | A beat is being presented |
| beatLast | output | 1 | Current beat is the final one |

## Verification
A corrupted beat counter or captured offset shows on `beatCol` at the very next beat. It appears as an out-of-order offset or a disturbed upper column bit. A wrong latched length moves `beatLast` to the wrong beat, or leaves `beatValid` high for one cycle too many or too few. Both errors are visible within at most eight cycles of the start. If the mode snapshot is missing, a mode write issued in the middle of a burst changes the remaining beats at once, on the next beat presented.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // Offset bits permuted by the longest burst (8 beats)
  localparam int OFS_W = 3;

  localparam logic [2:0] LEN_CODE_2 = 3'b001;
  localparam logic [2:0] LEN_CODE_4 = 3'b010;
  localparam logic [2:0] LEN_CODE_8 = 3'b011;

  // Strobes and state handed from control to datapath
  typedef struct packed {
    logic             load;
    logic             interleave;
    logic [OFS_W-1:0] beatIdx;
    logic [OFS_W-1:0] lenMask;
  } seqCtrl_t;

  function automatic logic [OFS_W-1:0] lenCodeMask(input logic [2:0] code);
    case (code)
      LEN_CODE_2: lenCodeMask = 3'b001;
      LEN_CODE_4: lenCodeMask = 3'b011;
      LEN_CODE_8: lenCodeMask = 3'b111;
      default:    lenCodeMask = 3'b000;
    endcase
  endfunction

  function automatic logic lenCodeOk(input logic [2:0] code);
    lenCodeOk = (code == LEN_CODE_2) || (code == LEN_CODE_4) || (code == LEN_CODE_8);
  endfunction
endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     modeWrEn,
  input  logic [3:0] modeBits,
  input  logic     start,
  input  logic     beatEn,
  output seqCtrl_t seqCtrl,
  output logic     beatValid,
  output logic     beatLast
);
  logic [2:0]       modeLen;
  logic             modeIlv;
  logic             active;
  logic [OFS_W-1:0] beatCnt;
  logic [OFS_W-1:0] burstMask;
  logic             startAccept;
  logic             onFinal;

  assign startAccept = start && lenCodeOk(modeLen);
  assign onFinal     = active && (beatCnt == burstMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeLen   <= 3'b000;
      modeIlv   <= 1'b0;
      active    <= 1'b0;
      beatCnt   <= '0;
      burstMask <= '0;
    end else begin
      if (modeWrEn) begin
        modeLen <= modeBits[2:0];
        modeIlv <= modeBits[3];
      end
      if (startAccept) begin
        active    <= 1'b1;
        beatCnt   <= '0;
        burstMask <= lenCodeMask(modeLen);
      end else if (active && beatEn) begin
        if (onFinal) active <= 1'b0;
        else         beatCnt <= beatCnt + 1'b1;
      end
    end
  end

  always_comb begin
    seqCtrl.load       = startAccept;
    seqCtrl.interleave = modeIlv;
    seqCtrl.beatIdx    = beatCnt;
    seqCtrl.lenMask    = burstMask;
  end

  assign beatValid = active;
  assign beatLast  = onFinal;
endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtrl_t         seqCtrl,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] beatCol
);
  logic [COL_W-1:0] baseCol;
  logic             ilvSel;
  logic [OFS_W-1:0] startOfs;
  logic [OFS_W-1:0] seqOfs;
  logic [OFS_W-1:0] ilvOfs;
  logic [OFS_W-1:0] pickOfs;
  logic [OFS_W-1:0] lowCol;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol <= '0;
      ilvSel  <= 1'b0;
    end else if (seqCtrl.load) begin
      baseCol <= startCol;
      ilvSel  <= seqCtrl.interleave;
    end
  end

  assign startOfs = baseCol[OFS_W-1:0];
  assign seqOfs   = startOfs + seqCtrl.beatIdx;
  assign ilvOfs   = startOfs ^ seqCtrl.beatIdx;
  assign pickOfs  = ilvSel ? ilvOfs : seqOfs;

  // Bits inside the burst follow the chosen order; bits above stay put
  for (genvar b = 0; b < OFS_W; b++) begin : g_ofsBit
    assign lowCol[b] = seqCtrl.lenMask[b] ? pickOfs[b] : startOfs[b];
  end

  assign beatCol = {baseCol[COL_W-1:OFS_W], lowCol};
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWrEn,
  input  logic [3:0]       modeBits,
  input  logic             start,
  input  logic [COL_W-1:0] startCol,
  input  logic             beatEn,
  output logic [COL_W-1:0] beatCol,
  output logic             beatValid,
  output logic             beatLast
);
  seqCtrl_t seqCtrl;
  logic     startAccept;

  bcs_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .modeWrEn  (modeWrEn),
    .modeBits  (modeBits),
    .start     (start),
    .beatEn    (beatEn),
    .seqCtrl   (seqCtrl),
    .beatValid (beatValid),
    .beatLast  (beatLast)
  );

  bcs_datapath #(.COL_W(COL_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .seqCtrl  (seqCtrl),
    .startCol (startCol),
    .beatCol  (beatCol)
  );

  assign startAccept = seqCtrl.load;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             startAccept,
  input logic             beatEn,
  input logic [COL_W-1:0] startCol,
  input logic [COL_W-1:0] beatCol,
  input logic             beatValid,
  input logic             beatLast
);
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    beatLast |-> beatValid); // R8

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    startAccept |=> (beatValid && beatCol == $past(startCol))); // R4

  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && beatLast && beatEn && !start) |=> !beatValid); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !beatEn && !start) |=> (beatValid && $stable(beatCol) && $stable(beatLast))); // R9

  AST_HIGH_BITS_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && $past(beatValid) && !$past(startAccept))
      |-> (beatCol[COL_W-1:3] == $past(beatCol[COL_W-1:3]))); // R7

  AST_RESERVED_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (!beatValid && start && !startAccept) |=> !beatValid); // R3
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .startAccept (startAccept),
  .beatEn      (beatEn),
  .startCol    (startCol),
  .beatCol     (beatCol),
  .beatValid   (beatValid),
  .beatLast    (beatLast)
);

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 11;
  localparam int NVEC = 8;

  typedef struct packed {
    logic [3:0]  mode;
    logic [10:0] col;
    logic [23:0] ord;   // beat 0 in the top three bits
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'b0001, 11'h001, {3'd1,3'd0,18'd0}},
    '{4'b1001, 11'h2A0, {3'd0,3'd1,18'd0}},
    '{4'b0010, 11'h00E, {3'd2,3'd3,3'd0,3'd1,12'd0}},
    '{4'b1010, 11'h137, {3'd3,3'd2,3'd1,3'd0,12'd0}},
    '{4'b0011, 11'h7FD, {3'd5,3'd6,3'd7,3'd0,3'd1,3'd2,3'd3,3'd4}},
    '{4'b1011, 11'h405, {3'd5,3'd4,3'd7,3'd6,3'd1,3'd0,3'd3,3'd2}},
    '{4'b1011, 11'h003, {3'd3,3'd2,3'd1,3'd0,3'd7,3'd6,3'd5,3'd4}},
    '{4'b0010, 11'h555, {3'd1,3'd2,3'd3,3'd0,12'd0}}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWrEn = 1'b0;
  logic [3:0] modeBits = 4'd0;
  logic start = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic beatEn = 1'b1;
  logic [COL_W-1:0] beatCol;
  logic beatValid;
  logic beatLast;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeBits(modeBits),
    .start(start), .startCol(startCol), .beatEn(beatEn),
    .beatCol(beatCol), .beatValid(beatValid), .beatLast(beatLast)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeMode(input logic [3:0] m);
    @(negedge clk); modeWrEn = 1'b1; modeBits = m;
    @(negedge clk); modeWrEn = 1'b0;
  endtask

  task automatic pulseStart(input logic [COL_W-1:0] c);
    @(negedge clk); start = 1'b1; startCol = c;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid after reset", beatValid, 0);
    check("R1 last after reset", beatLast, 0);
    rstN = 1'b1;
    pulseStart(11'h010);
    check("R1 start ignored before mode write", beatValid, 0);

    // Table walk: R4 first beat, R5 sequential, R6 interleaved, R7 high bits, R8 last
    for (int v = 0; v < NVEC; v++) begin
      int len;
      string req;
      len = 1 << VECS[v].mode[1:0];
      req = VECS[v].mode[3] ? "R6 interleaved order" : "R5 sequential order";
      writeMode(VECS[v].mode);
      pulseStart(VECS[v].col);
      for (int i = 0; i < len; i++) begin
        logic [10:0] exp;
        exp = (VECS[v].col & ~11'(len - 1)) | 11'(VECS[v].ord[23 - 3*i -: 3]);
        check(req, beatCol, exp);
        check("R4 valid during burst", beatValid, 1);
        check("R8 last flag", beatLast, (i == len - 1));
        @(negedge clk);
      end
      check("R8 valid drops after last", beatValid, 0);
    end

    // R3 reserved length codes
    writeMode(4'b0100);
    pulseStart(11'h020);
    check("R3 reserved code 100", beatValid, 0);
    writeMode(4'b1111);
    pulseStart(11'h020);
    check("R3 reserved code 111", beatValid, 0);
    writeMode(4'b0000);
    pulseStart(11'h020);
    check("R3 reserved code 000", beatValid, 0);

    // R9 stall holds the beat
    writeMode(4'b0010);
    @(negedge clk); start = 1'b1; startCol = 11'h040;
    @(negedge clk); start = 1'b0; beatEn = 1'b0;
    check("R9 beat0", beatCol, 11'h040);
    @(negedge clk);
    check("R9 hold col", beatCol, 11'h040);
    check("R9 hold valid", beatValid, 1);
    @(negedge clk);
    check("R9 hold col again", beatCol, 11'h040);
    beatEn = 1'b1;
    @(negedge clk);
    check("R9 resume", beatCol, 11'h041);
    repeat (3) @(negedge clk);
    check("R9 burst end", beatValid, 0);

    // R10 restart during a burst
    writeMode(4'b0011);
    pulseStart(11'h010);
    @(negedge clk);
    check("R10 before restart", beatCol, 11'h011);
    start = 1'b1; startCol = 11'h023;
    @(negedge clk); start = 1'b0;
    check("R10 restart first beat", beatCol, 11'h023);
    check("R10 restart last clear", beatLast, 0);
    @(negedge clk);
    check("R10 restart second beat", beatCol, 11'h024);
    repeat (6) @(negedge clk);
    check("R10 restart final beat", beatCol, 11'h022);
    check("R10 restart final last", beatLast, 1);
    @(negedge clk);
    check("R10 ends after 8", beatValid, 0);

    // R11 mode write mid-burst
    writeMode(4'b1010);
    pulseStart(11'h081);
    check("R11 beat0", beatCol, 11'h081);
    modeWrEn = 1'b1; modeBits = 4'b0001;
    @(negedge clk); modeWrEn = 1'b0;
    check("R11 beat1", beatCol, 11'h080);
    check("R11 beat1 not last", beatLast, 0);
    @(negedge clk);
    check("R11 beat2", beatCol, 11'h083);
    @(negedge clk);
    check("R11 beat3", beatCol, 11'h082);
    check("R11 beat3 last", beatLast, 1);
    @(negedge clk);
    check("R11 ends", beatValid, 0);

    // R2 same-edge mode write uses old mode (length 2 sequential)
    @(negedge clk); modeWrEn = 1'b1; modeBits = 4'b1011; start = 1'b1; startCol = 11'h006;
    @(negedge clk); modeWrEn = 1'b0; start = 1'b0;
    check("R2 old mode beat0", beatCol, 11'h006);
    @(negedge clk);
    check("R2 old mode beat1", beatCol, 11'h007);
    check("R2 old mode last", beatLast, 1);
    @(negedge clk);
    check("R2 old mode ends", beatValid, 0);
    pulseStart(11'h006);
    @(negedge clk);
    check("R2 new mode interleaved beat1", beatCol, 11'h007);
    @(negedge clk);
    check("R2 new mode beat2", beatCol, 11'h004);
    check("R2 new mode not last", beatLast, 0);
    repeat (6) @(negedge clk);
    check("R2 new mode ends after 8", beatValid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule